// File: doc/BRIEF.md
# Byte-Lane Dual-Port Memory

This block is a 16-bit-wide memory with two fully independent access ports, called left and right. Each port has its own address, write data, registered read data and control pins. The controls are an active-low chip enable, a read/write select, an active-low output enable, one active-low select per data byte, and an active-low semaphore select. Both ports can reach every word in the same clock cycle.

On every clock each port turns its control pins into an access mode. The mode decides which byte lanes are written or read. Each port reports its mode and a drive flag per byte lane, registered one clock after the controls were sampled, so a surrounding pad model can switch its tri-state buffers from those flags. A lane that is not driven returns zero on the read-data bus.

Busy arbitration between the ports is not part of this block. When both ports write overlapping lanes of one word in the same cycle, the left port's data is stored and a collision flag reports the event.

Top module: `dpm_byte_lane_ram`

## Requirements
- R1: Each port takes a 13-bit address. With the default depth of 4096 words only the low 12 bits select a word, and the top bit is ignored, so address 0x1007 reaches the same word as 0x0007.
- R2: With chip enable high, the port reports mode OFF (code 0), drives no lane and writes nothing, whatever its other controls are.
- R3: With chip enable low and semaphore select low, the port reports mode SEM (code 5), drives no lane and makes no memory access.
- R4: With chip enable low, semaphore select high and both byte selects high, the port reports mode NOSEL (code 1), drives no lane and writes nothing.
- R5: With chip enable low, semaphore select high, read/write low and at least one byte select low, the port reports mode WRITE (code 2). Byte select bit 1 gates data bits 15:8 and bit 0 gates bits 7:0, each on its own. Output enable has no effect on a write, and no lane is driven.
- R6: With chip enable low, semaphore select high, read/write high, output enable low and at least one byte select low, the port reports mode READ (code 3). Exactly the lanes whose select is low are flagged as driven and carry memory data. Lanes that are not driven read as zero.
- R7: A read set-up with output enable high reports mode HIZ (code 4) and drives no lane.
- R8: Mode, drive flags and read data change one clock after the controls are sampled. Reset clears all of them and the collision flag to zero.
- R9: Both ports can read the same word in the same cycle, and each port gets that word on its own selected lanes.
- R10: If both ports write the same word in one cycle, a lane selected by both takes the left port's data, and a lane selected by only one takes that port's data. collision_o goes high for one clock exactly when the two ports' write lanes overlap on the same word.
- R11: A read of a word that the other port writes in the same cycle returns the content from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_rw_i | input | 1 | Left read (1) / write (0) |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_be_ni | input | 2 | Left byte selects, active low, bit 1 = upper |
| l_sem_ni | input | 1 | Left semaphore select, active low; must be high for memory access |
| l_addr_i | input | 13 | Left word address |
| l_wdata_i | input | 16 | Left write data |
| l_rdata_o | output | 16 | Left registered read data, zero on lanes that are not driven |
| l_drive_o | output | 2 | Left per-lane drive flags |
| l_mode_o | output | 3 | Left registered mode code |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_rw_i | input | 1 | Right read (1) / write (0) |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_be_ni | input | 2 | Right byte selects, active low, bit 1 = upper |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_addr_i | input | 13 | Right word address |
| r_wdata_i | input | 16 | Right write data |
| r_rdata_o | output | 16 | Right registered read data |
| r_drive_o | output | 2 | Right per-lane drive flags |
| r_mode_o | output | 3 | Right registered mode code |
| collision_o | output | 1 | Same-word write overlap seen in the previous cycle |

## Verification
All 64 combinations of chip enable, read/write, output enable, the two byte selects and semaphore select are applied on each port in turn. Each combination goes to its own preloaded word, and the bench then reads every one of those words back from the other port. This separates the controls that block a write from those that only block driving. Directed patterns use single-lane writes followed by single-lane reads to show that the lanes are independent. Same-word writes from both ports, first with overlapping lanes and then with disjoint lanes, show that the left port wins and that the collision flag fires only on a real overlap. Aliased addresses, a read of one word from both ports in the same cycle, and a read that meets a write from the other port cover the addressing and ordering cases.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_NOSEL = 3'd1,
    MODE_WRITE = 3'd2,
    MODE_READ  = 3'd3,
    MODE_HIZ   = 3'd4,
    MODE_SEM   = 3'd5
  } port_mode_e;
endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
  import dpm_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             ce_ni,
  input  logic             rw_i,
  input  logic             oe_ni,
  input  logic [LANES-1:0] be_ni,
  input  logic             sem_ni,
  output port_mode_e       mode_o,
  output logic [LANES-1:0] wr_lane_o,
  output logic [LANES-1:0] rd_lane_o
);
  // priority: enable, semaphore, lane select, direction, output enable
  always_comb begin
    if (ce_ni)                mode_o = MODE_OFF;
    else if (!sem_ni)         mode_o = MODE_SEM;
    else if (&be_ni)          mode_o = MODE_NOSEL;
    else if (!rw_i)           mode_o = MODE_WRITE;
    else if (oe_ni)           mode_o = MODE_HIZ;
    else                      mode_o = MODE_READ;
  end

  assign wr_lane_o = (mode_o == MODE_WRITE) ? ~be_ni : '0;
  assign rd_lane_o = (mode_o == MODE_READ)  ? ~be_ni : '0;
endmodule

// File: rtl/dpm_mem_core.sv
module dpm_mem_core #(
  parameter int DEPTH_AW = 12,
  parameter int BYTE_W   = 8,
  parameter int LANES    = 2,
  localparam int DEPTH   = 1 << DEPTH_AW,
  localparam int DATA_W  = BYTE_W * LANES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DEPTH_AW-1:0] l_addr_i,
  input  logic [LANES-1:0]    l_wr_i,
  input  logic [LANES-1:0]    l_rd_i,
  input  logic [DATA_W-1:0]   l_wdata_i,
  output logic [DATA_W-1:0]   l_rdata_o,
  input  logic [DEPTH_AW-1:0] r_addr_i,
  input  logic [LANES-1:0]    r_wr_i,
  input  logic [LANES-1:0]    r_rd_i,
  input  logic [DATA_W-1:0]   r_wdata_i,
  output logic [DATA_W-1:0]   r_rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] l_rd_q, r_rd_q;

    // left write placed last so it wins on a shared word
    always_ff @(posedge clk_i) begin
      if (r_wr_i[g]) mem_q[r_addr_i] <= r_wdata_i[g*BYTE_W +: BYTE_W];
      if (l_wr_i[g]) mem_q[l_addr_i] <= l_wdata_i[g*BYTE_W +: BYTE_W];
    end

    // read-before-write: sees the array content ahead of this edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        l_rd_q <= '0;
        r_rd_q <= '0;
      end else begin
        l_rd_q <= l_rd_i[g] ? mem_q[l_addr_i] : '0;
        r_rd_q <= r_rd_i[g] ? mem_q[r_addr_i] : '0;
      end
    end

    assign l_rdata_o[g*BYTE_W +: BYTE_W] = l_rd_q;
    assign r_rdata_o[g*BYTE_W +: BYTE_W] = r_rd_q;
  end
endmodule

// File: rtl/dpm_byte_lane_ram.sv
module dpm_byte_lane_ram
  import dpm_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DEPTH_AW = 12,
  parameter int BYTE_W   = 8,
  parameter int LANES    = 2,
  localparam int DATA_W  = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_rw_i,
  input  logic              l_oe_ni,
  input  logic [LANES-1:0]  l_be_ni,
  input  logic              l_sem_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic [LANES-1:0]  l_drive_o,
  output logic [2:0]        l_mode_o,
  input  logic              r_ce_ni,
  input  logic              r_rw_i,
  input  logic              r_oe_ni,
  input  logic [LANES-1:0]  r_be_ni,
  input  logic              r_sem_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic [LANES-1:0]  r_drive_o,
  output logic [2:0]        r_mode_o,
  output logic              collision_o
);
  port_mode_e          l_mode, r_mode;
  logic [LANES-1:0]    l_wr, l_rd, r_wr, r_rd;
  logic [DEPTH_AW-1:0] l_eff, r_eff;
  logic                coll_d;

  assign l_eff = l_addr_i[DEPTH_AW-1:0];
  assign r_eff = r_addr_i[DEPTH_AW-1:0];

  if (DEPTH_AW < ADDR_W) begin : g_alias
    logic unused_addr_hi;
    assign unused_addr_hi = ^{l_addr_i[ADDR_W-1:DEPTH_AW], r_addr_i[ADDR_W-1:DEPTH_AW]};
  end

  dpm_port_decode #(.LANES(LANES)) u_dec_l (
    .ce_ni(l_ce_ni), .rw_i(l_rw_i), .oe_ni(l_oe_ni), .be_ni(l_be_ni), .sem_ni(l_sem_ni),
    .mode_o(l_mode), .wr_lane_o(l_wr), .rd_lane_o(l_rd)
  );

  dpm_port_decode #(.LANES(LANES)) u_dec_r (
    .ce_ni(r_ce_ni), .rw_i(r_rw_i), .oe_ni(r_oe_ni), .be_ni(r_be_ni), .sem_ni(r_sem_ni),
    .mode_o(r_mode), .wr_lane_o(r_wr), .rd_lane_o(r_rd)
  );

  dpm_mem_core #(.DEPTH_AW(DEPTH_AW), .BYTE_W(BYTE_W), .LANES(LANES)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .l_addr_i(l_eff), .l_wr_i(l_wr), .l_rd_i(l_rd), .l_wdata_i(l_wdata_i), .l_rdata_o(l_rdata_o),
    .r_addr_i(r_eff), .r_wr_i(r_wr), .r_rd_i(r_rd), .r_wdata_i(r_wdata_i), .r_rdata_o(r_rdata_o)
  );

  assign coll_d = (l_eff == r_eff) && |(l_wr & r_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_drive_o   <= '0;
      r_drive_o   <= '0;
      l_mode_o    <= MODE_OFF;
      r_mode_o    <= MODE_OFF;
      collision_o <= 1'b0;
    end else begin
      l_drive_o   <= l_rd;
      r_drive_o   <= r_rd;
      l_mode_o    <= l_mode;
      r_mode_o    <= r_mode;
      collision_o <= coll_d;
    end
  end
endmodule

// File: rtl/dpm_byte_lane_ram_chk.sv
module dpm_byte_lane_ram_chk #(
  parameter int ADDR_W   = 13,
  parameter int DEPTH_AW = 12,
  parameter int BYTE_W   = 8,
  parameter int LANES    = 2,
  localparam int DATA_W  = BYTE_W * LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_ce_ni,
  input logic              l_rw_i,
  input logic              l_oe_ni,
  input logic [LANES-1:0]  l_be_ni,
  input logic              l_sem_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic [LANES-1:0]  l_drive_o,
  input logic [2:0]        l_mode_o,
  input logic              r_ce_ni,
  input logic              r_rw_i,
  input logic              r_oe_ni,
  input logic [LANES-1:0]  r_be_ni,
  input logic              r_sem_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic [DATA_W-1:0] r_rdata_o,
  input logic [LANES-1:0]  r_drive_o,
  input logic [2:0]        r_mode_o,
  input logic              collision_o
);
  logic l_rd_cfg, r_rd_cfg, l_wr_cfg, r_wr_cfg, same_word;
  assign l_rd_cfg  = !l_ce_ni && l_sem_ni && l_rw_i && !l_oe_ni;
  assign r_rd_cfg  = !r_ce_ni && r_sem_ni && r_rw_i && !r_oe_ni;
  assign l_wr_cfg  = !l_ce_ni && l_sem_ni && !l_rw_i;
  assign r_wr_cfg  = !r_ce_ni && r_sem_ni && !r_rw_i;
  assign same_word = l_addr_i[DEPTH_AW-1:0] == r_addr_i[DEPTH_AW-1:0];

  a_r2_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_ce_ni |=> (l_drive_o == '0) && (l_mode_o == 3'd0));
  a_r2_off_quiet_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_ce_ni |=> (r_drive_o == '0) && (r_mode_o == 3'd0));
  a_r3_sem_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce_ni && !l_sem_ni) |=> (l_drive_o == '0) && (l_mode_o == 3'd5));
  a_r4_nosel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce_ni && l_sem_ni && (&l_be_ni)) |=> (l_drive_o == '0));
  a_r5_write_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_wr_cfg |=> (l_drive_o == '0));
  a_r6_lane_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_rd_cfg |=> (l_drive_o == ~$past(l_be_ni)));
  a_r7_oe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce_ni && l_sem_ni && l_rw_i && l_oe_ni) |=> (l_drive_o == '0));
  a_r9_shared_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rd_cfg && r_rd_cfg && same_word && (l_be_ni == r_be_ni)) |=> (l_rdata_o == r_rdata_o));
  a_r10_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr_cfg && r_wr_cfg && same_word && ((~l_be_ni & ~r_be_ni) != '0)) |=> collision_o);
  a_r10_no_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_wr_cfg && r_wr_cfg) |=> !collision_o);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    a_r6_undriven_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !l_drive_o[g] |-> (l_rdata_o[g*BYTE_W +: BYTE_W] == '0));
    a_r6_undriven_zero_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !r_drive_o[g] |-> (r_rdata_o[g*BYTE_W +: BYTE_W] == '0));
  end
endmodule

bind dpm_byte_lane_ram dpm_byte_lane_ram_chk #(
  .ADDR_W(ADDR_W), .DEPTH_AW(DEPTH_AW), .BYTE_W(BYTE_W), .LANES(LANES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_ce_ni(l_ce_ni), .l_rw_i(l_rw_i), .l_oe_ni(l_oe_ni), .l_be_ni(l_be_ni),
  .l_sem_ni(l_sem_ni), .l_addr_i(l_addr_i), .l_rdata_o(l_rdata_o),
  .l_drive_o(l_drive_o), .l_mode_o(l_mode_o),
  .r_ce_ni(r_ce_ni), .r_rw_i(r_rw_i), .r_oe_ni(r_oe_ni), .r_be_ni(r_be_ni),
  .r_sem_ni(r_sem_ni), .r_addr_i(r_addr_i), .r_rdata_o(r_rdata_o),
  .r_drive_o(r_drive_o), .r_mode_o(r_mode_o), .collision_o(collision_o)
);

// File: tb/tb_dpm_byte_lane_ram.sv
`timescale 1ns/1ps
module tb_dpm_byte_lane_ram;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic l_ce_ni, l_rw_i, l_oe_ni, l_sem_ni;
  logic [1:0] l_be_ni;
  logic [12:0] l_addr_i;
  logic [15:0] l_wdata_i, l_rdata_o;
  logic [1:0] l_drive_o;
  logic [2:0] l_mode_o;
  logic r_ce_ni, r_rw_i, r_oe_ni, r_sem_ni;
  logic [1:0] r_be_ni;
  logic [12:0] r_addr_i;
  logic [15:0] r_wdata_i, r_rdata_o;
  logic [1:0] r_drive_o;
  logic [2:0] r_mode_o;
  logic collision_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] model_q [4096];

  always #10 clk = ~clk;

  dpm_byte_lane_ram dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_ce_ni(l_ce_ni), .l_rw_i(l_rw_i), .l_oe_ni(l_oe_ni), .l_be_ni(l_be_ni),
    .l_sem_ni(l_sem_ni), .l_addr_i(l_addr_i), .l_wdata_i(l_wdata_i),
    .l_rdata_o(l_rdata_o), .l_drive_o(l_drive_o), .l_mode_o(l_mode_o),
    .r_ce_ni(r_ce_ni), .r_rw_i(r_rw_i), .r_oe_ni(r_oe_ni), .r_be_ni(r_be_ni),
    .r_sem_ni(r_sem_ni), .r_addr_i(r_addr_i), .r_wdata_i(r_wdata_i),
    .r_rdata_o(r_rdata_o), .r_drive_o(r_drive_o), .r_mode_o(r_mode_o),
    .collision_o(collision_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_mode(logic ce, logic rw, logic oe, logic [1:0] be, logic sem);
    if (ce) return 3'd0;
    if (!sem) return 3'd5;
    if (be == 2'b11) return 3'd1;
    if (!rw) return 3'd2;
    if (oe) return 3'd4;
    return 3'd3;
  endfunction

  function automatic logic [15:0] lane_mask(logic [1:0] lanes);
    return {{8{lanes[1]}}, {8{lanes[0]}}};
  endfunction

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic set_port(int p, logic ce, logic rw, logic oe, logic [1:0] be, logic sem,
                          logic [12:0] a, logic [15:0] d);
    if (p == 0) begin
      l_ce_ni = ce; l_rw_i = rw; l_oe_ni = oe; l_be_ni = be; l_sem_ni = sem;
      l_addr_i = a; l_wdata_i = d;
    end else begin
      r_ce_ni = ce; r_rw_i = rw; r_oe_ni = oe; r_be_ni = be; r_sem_ni = sem;
      r_addr_i = a; r_wdata_i = d;
    end
  endtask

  task automatic idle_all();
    set_port(0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, '0, '0);
    set_port(1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, '0, '0);
  endtask

  task automatic do_write(int p, logic [12:0] a, logic [1:0] be, logic [15:0] d);
    idle_all();
    set_port(p, 1'b0, 1'b0, 1'b1, be, 1'b1, a, d);
    cyc();
    model_q[a[11:0]] = (model_q[a[11:0]] & ~lane_mask(~be)) | (d & lane_mask(~be));
    idle_all();
  endtask

  task automatic do_read(int p, logic [12:0] a, logic [1:0] be, output logic [15:0] q,
                         output logic [1:0] drv);
    idle_all();
    set_port(p, 1'b0, 1'b1, 1'b0, be, 1'b1, a, '0);
    cyc();
    q   = (p == 0) ? l_rdata_o : r_rdata_o;
    drv = (p == 0) ? l_drive_o : r_drive_o;
    idle_all();
  endtask

  task automatic t_reset();
    idle_all();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset l_mode", l_mode_o, 3'd0);
    check("R8 reset drive", {l_drive_o, r_drive_o}, 4'd0);
    check("R8 reset rdata", {l_rdata_o, r_rdata_o}, 32'd0);
    check("R8 reset collision", collision_o, 1'b0);
    rst_ni = 1'b1;
    cyc();
  endtask

  task automatic t_lanes();
    logic [15:0] q; logic [1:0] drv;
    idle_all();
    set_port(0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 13'h040, 16'hA5C3); // oe low on a write: R5
    cyc();
    model_q[12'h040] = 16'hA5C3;
    check("R5 write mode", l_mode_o, 3'd2);
    check("R5 write no drive", l_drive_o, 2'b00);
    idle_all();
    set_port(0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 13'h040, '0);
    #5;
    check("R8 no change before edge", l_drive_o, 2'b00);
    cyc();
    check("R6 full read data", l_rdata_o, 16'hA5C3);
    check("R6 full read drive", l_drive_o, 2'b11);
    check("R6 read mode", l_mode_o, 3'd3);
    do_write(0, 13'h040, 2'b01, 16'h1177);
    do_read(1, 13'h040, 2'b00, q, drv);
    check("R5 upper-only write", q, 16'h11C3);
    do_write(1, 13'h040, 2'b10, 16'h99EE);
    do_read(0, 13'h040, 2'b00, q, drv);
    check("R5 lower-only write", q, 16'h11EE);
    do_read(0, 13'h040, 2'b01, q, drv);
    check("R6 upper-only read data", q, 16'h1100);
    check("R6 upper-only read drive", drv, 2'b10);
    do_read(1, 13'h040, 2'b10, q, drv);
    check("R6 lower-only read data", q, 16'h00EE);
    check("R6 lower-only read drive", drv, 2'b01);
  endtask

  task automatic t_sweep(int p);
    logic [15:0] q; logic [1:0] drv;
    for (int a = 0; a < 64; a++) do_write(1 - p, 13'h100 + 13'(a), 2'b00, 16'h3C00 ^ 16'(a * 263));
    for (int c = 0; c < 64; c++) begin
      logic ce, rw, oe, sem;
      logic [1:0] be, edrv;
      logic [2:0] em;
      logic [12:0] a;
      logic [15:0] d, erd;
      ce = c[5]; rw = c[4]; oe = c[3]; be = 2'(c >> 1); sem = c[0];
      a = 13'h100 + 13'(c);
      d = 16'h5A3C ^ 16'(c * 16'h0101);
      em = exp_mode(ce, rw, oe, be, sem);
      edrv = (em == 3'd3) ? ~be : 2'b00;
      erd = model_q[a[11:0]] & lane_mask(edrv);
      idle_all();
      set_port(p, ce, rw, oe, be, sem, a, d);
      cyc();
      // R2 R3 R4 R5 R6 R7: mode code, drive flags and masked data per combination
      check("R2-7 sweep mode", (p == 0) ? l_mode_o : r_mode_o, em);
      check("R6 sweep drive", (p == 0) ? l_drive_o : r_drive_o, edrv);
      check("R6 sweep data", (p == 0) ? l_rdata_o : r_rdata_o, erd);
      if (em == 3'd2) model_q[a[11:0]] = (model_q[a[11:0]] & ~lane_mask(~be)) | (d & lane_mask(~be));
    end
    idle_all();
    for (int c = 0; c < 64; c++) begin
      do_read(1 - p, 13'h100 + 13'(c), 2'b00, q, drv);
      check("R2 R3 R4 R7 sweep readback", q, model_q[12'h100 + 12'(c)]);
    end
  endtask

  task automatic t_alias();
    logic [15:0] q; logic [1:0] drv;
    do_write(0, 13'h1007, 2'b00, 16'hBEEF);
    do_read(1, 13'h0007, 2'b00, q, drv);
    check("R1 alias low address", q, 16'hBEEF);
    do_write(1, 13'h0007, 2'b10, 16'h0042);
    do_read(0, 13'h1007, 2'b00, q, drv);
    check("R1 alias high address", q, 16'hBE42);
  endtask

  task automatic t_dual_read();
    do_write(0, 13'h105, 2'b00, 16'h6D2B);
    idle_all();
    set_port(0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 13'h105, '0);
    set_port(1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 13'h105, '0);
    cyc();
    check("R9 left shared read", l_rdata_o, 16'h6D2B);
    check("R9 right shared read", r_rdata_o, 16'h6D2B);
    set_port(0, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 13'h105, '0);
    set_port(1, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 13'h105, '0);
    cyc();
    check("R9 left upper lane", {l_drive_o, l_rdata_o}, {2'b10, 16'h6D00});
    check("R9 right lower lane", {r_drive_o, r_rdata_o}, {2'b01, 16'h002B});
    idle_all();
  endtask

  task automatic t_collision();
    logic [15:0] q; logic [1:0] drv;
    idle_all();
    set_port(0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 13'h020, 16'hAA55);
    set_port(1, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 13'h020, 16'hBBCC);
    cyc();
    check("R10 overlap flags collision", collision_o, 1'b1);
    idle_all();
    cyc();
    check("R10 collision lasts one clock", collision_o, 1'b0);
    do_read(0, 13'h020, 2'b00, q, drv);
    check("R10 left wins shared lane", q, 16'hAACC);
    set_port(0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 13'h023, 16'h1234);
    set_port(1, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 13'h023, 16'h5678);
    cyc();
    check("R10 disjoint lanes no collision", collision_o, 1'b0);
    set_port(0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 13'h021, 16'h0F0F);
    set_port(1, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 13'h022, 16'hF0F0);
    cyc();
    check("R10 distinct words no collision", collision_o, 1'b0);
    idle_all();
    do_read(1, 13'h023, 2'b00, q, drv);
    check("R10 disjoint lanes merge", q, 16'h1278);
    do_read(1, 13'h021, 2'b00, q, drv);
    check("R10 distinct word left", q, 16'h0F0F);
    do_read(0, 13'h022, 2'b00, q, drv);
    check("R10 distinct word right", q, 16'hF0F0);
  endtask

  task automatic t_rbw();
    logic [15:0] q; logic [1:0] drv;
    do_write(0, 13'h030, 2'b00, 16'h1234);
    set_port(0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 13'h030, 16'h5678);
    set_port(1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 13'h030, '0);
    cyc();
    check("R11 read sees old word", r_rdata_o, 16'h1234);
    idle_all();
    do_read(1, 13'h030, 2'b00, q, drv);
    check("R11 next read sees new word", q, 16'h5678);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin
    t_reset();
    t_lanes();
    t_sweep(0);
    t_sweep(1);
    t_alias();
    t_dual_read();
    t_collision();
    t_rbw();
    finish_run();
  end
endmodule